// File: doc/BRIEF.md
# Serial EEPROM Read Sequencer

This block fetches a run of bytes from a serial EEPROM over a four-wire link made of a chip select, a serial clock, a data line toward the memory and a data line back from it. A requester supplies a 16-bit start offset and a byte count with a one-cycle request pulse. The block adds the low half of a configured base offset to form the memory address. It raises a link-enable output and selects the memory. It then clocks out a read command and the two address bytes, and clocks in the requested bytes.

Each received byte appears on a data port together with a one-cycle valid strobe. After the last byte the block releases the select line, drops the link enable and pulses `done`. A request that cannot be served is refused with a one-cycle `error` pulse and causes no link activity. This happens when the base offset does not fit in 16 bits or when the presence flags show that no memory is fitted. The speed of the serial clock is set by a half-period input counted in system clocks.

Top module: `spi_rom_reader`

## Requirements
- R1: An access opens with `link_en` rising on the clock edge after acceptance and `cs_n` falling one edge later. It closes with `cs_n` rising, then `link_en` falling one edge later. `cs_n` is never low while `link_en` is low.
- R2: Bits are sent and received most significant first. The first bit after select is bit 7 of the command byte, and the first bit returned by the memory is bit 7 of a data byte.
- R3: An outgoing bit is placed on `mosi` while `sclk` is low and does not change while `sclk` is high. An incoming bit on `miso` is captured at the end of the `sclk` high phase.
- R4: Each access sends byte 0x03, then address bits 15:8, then address bits 7:0. It then reads `req_count` bytes, each given on `rd_data` with a one-cycle `rd_valid`, in address order.
- R5: The memory address is `req_offset` plus `cfg_base[15:0]`, modulo 65536.
- R6: A request is refused when `cfg_base` exceeds 0xFFFF, when `cfg_present` is 0, or when `cfg_absent` is 1. `error` pulses for one cycle on the edge after the request. `busy`, `link_en` and `cs_n` stay idle.
- R7: Every `sclk` high phase and low phase inside a byte lasts `cfg_half` system clocks, or one clock when `cfg_half` is 0.
- R8: `busy` rises with `link_en` and stays high until the edge after `cs_n` is released. It falls in the same cycle that `done` pulses.
- R9: A request pulse that arrives while `busy` is high is ignored: it adds no bytes, no `done` and no further access.
- R10: A byte count of zero still sends the command and both address bytes. It then closes the access with `done` and no `rd_valid` strobe.
- R11: After reset `cs_n` is 1 and `link_en`, `sclk`, `mosi`, `busy`, `rd_valid`, `done` and `error` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | One-cycle read request |
| req_offset | input | 16 | Start offset relative to the base |
| req_count | input | CNT_W | Number of bytes to read |
| cfg_base | input | 32 | Base offset added to every address |
| cfg_present | input | 1 | Memory present flag |
| cfg_absent | input | 1 | Memory absent flag |
| cfg_half | input | HALF_W | Serial clock half period in system clocks |
| busy | output | 1 | Access in progress |
| rd_valid | output | 1 | Strobe for `rd_data` |
| rd_data | output | 8 | Received byte |
| done | output | 1 | Access finished |
| error | output | 1 | Request refused |
| link_en | output | 1 | Serial link drive enable |
| cs_n | output | 1 | Memory select, active low |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Data toward the memory |
| miso | input | 1 | Data from the memory |

## Verification
A request driven before an edge shows its first results on that edge: `error`, or else `link_en` and `busy`. `cs_n` falls one edge later. At the close, `done`, the drop of `busy` and the fall of `link_en` all come one edge after `cs_n` rises. The bench samples half a clock after each edge and compares these exact cycles. Received bytes arrive at a rate set by `cfg_half`, so they are not timed. A queue holds them in expected order, and each strobe is compared as it appears. The memory model records what was shifted in on each rising `sclk`, and at `done` that record is compared with the expected command and address. The width of the `sclk` high phase is counted in system clocks and compared with the configured half period.

// File: rtl/rom_rd_pkg.sv
package rom_rd_pkg;
  localparam int unsigned BASE_W = 32;
  localparam logic [7:0] READ_OP = 8'h03;
  localparam int unsigned HDR_BYTES = 3;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ENA,
    ST_SEL,
    ST_XFER,
    ST_DESEL
  } seq_st_t;

  function automatic logic [15:0] eff_addr(input logic [15:0] off,
                                           input logic [BASE_W-1:0] base);
    return off + base[15:0];
  endfunction

  function automatic logic refuse(input logic [BASE_W-1:0] base,
                                  input logic present, input logic absent);
    return (|base[BASE_W-1:16]) || !present || absent;
  endfunction
endpackage

// File: rtl/rom_rd_timer.sv
module rom_rd_timer #(
  parameter int unsigned HALF_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [HALF_W-1:0] half,
  output logic              zero
);
  logic [HALF_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else if (load) cnt <= (half == '0) ? '0 : half - 1'b1;
    else if (cnt != '0) cnt <= cnt - 1'b1;
  end

  assign zero = (cnt == '0);

  AST_TIMER_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (half != '0) |-> (cnt < half) || $changed(half)) else $error("timer"); // R7
endmodule

// File: rtl/rom_rd_shift.sv
module rom_rd_shift #(
  parameter int unsigned HALF_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [7:0]        tx,
  input  logic [HALF_W-1:0] half,
  input  logic              miso,
  output logic              sclk,
  output logic              mosi,
  output logic              done,
  output logic [7:0]        rx
);
  logic       active;
  logic [2:0] bitn;
  logic [7:0] sh;
  logic       t_zero;
  logic       phase_end;
  logic       last_fall;
  logic       t_load;

  assign phase_end = active && t_zero;
  assign last_fall = phase_end && sclk && (bitn == 3'd7);
  assign t_load    = start || (phase_end && !last_fall);

  rom_rd_timer #(.HALF_W(HALF_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(t_load), .half(half), .zero(t_zero)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      sclk   <= 1'b0;
      mosi   <= 1'b0;
      done   <= 1'b0;
      bitn   <= '0;
      sh     <= '0;
    end else begin
      done <= 1'b0;
      if (start) begin
        active <= 1'b1;
        sh     <= tx;
        mosi   <= tx[7];
        sclk   <= 1'b0;
        bitn   <= '0;
      end else if (phase_end) begin
        if (!sclk) begin
          sclk <= 1'b1;
        end else begin
          sh   <= {sh[6:0], miso};
          sclk <= 1'b0;
          if (bitn == 3'd7) begin
            active <= 1'b0;
            done   <= 1'b1;
            mosi   <= 1'b0;
          end else begin
            bitn <= bitn + 1'b1;
            mosi <= sh[6];
          end
        end
      end
    end
  end

  assign rx = sh;

  AST_MOSI_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sclk) |-> $stable(mosi)) else $error("mosi moved at rise"); // R3
  AST_SCLK_ONLY_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
    sclk |-> active) else $error("stray sclk"); // R3
endmodule

// File: rtl/spi_rom_reader.sv
module spi_rom_reader
  import rom_rd_pkg::*;
#(
  parameter int unsigned CNT_W  = 8,
  parameter int unsigned HALF_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [15:0]       req_offset,
  input  logic [CNT_W-1:0]  req_count,
  input  logic [31:0]       cfg_base,
  input  logic              cfg_present,
  input  logic              cfg_absent,
  input  logic [HALF_W-1:0] cfg_half,
  output logic              busy,
  output logic              rd_valid,
  output logic [7:0]        rd_data,
  output logic              done,
  output logic              error,
  output logic              link_en,
  output logic              cs_n,
  output logic              sclk,
  output logic              mosi,
  input  logic              miso
);
  localparam int unsigned IDX_W = CNT_W + 2;

  seq_st_t          st;
  logic [15:0]      addr;
  logic [IDX_W-1:0] total;
  logic [IDX_W-1:0] idx;
  logic [IDX_W-1:0] nidx;
  logic             sh_start;
  logic             sh_done;
  logic [7:0]       sh_rx;
  logic [7:0]       sh_tx;
  logic             bad_req;
  logic             accept_ev;
  logic             reject_ev;
  logic             last_byte;

  assign bad_req   = refuse(cfg_base, cfg_present, cfg_absent);
  assign accept_ev = (st == ST_IDLE) && req_valid && !bad_req;
  assign reject_ev = (st == ST_IDLE) && req_valid && bad_req;
  assign last_byte = (idx == total - 1'b1);
  assign nidx      = (st == ST_SEL) ? '0 : idx + 1'b1;
  assign sh_start  = (st == ST_SEL) || ((st == ST_XFER) && sh_done && !last_byte);

  always_comb begin
    if (nidx == IDX_W'(0))      sh_tx = READ_OP;
    else if (nidx == IDX_W'(1)) sh_tx = addr[15:8];
    else if (nidx == IDX_W'(2)) sh_tx = addr[7:0];
    else                        sh_tx = 8'h00;
  end

  rom_rd_shift #(.HALF_W(HALF_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .start(sh_start), .tx(sh_tx), .half(cfg_half),
    .miso(miso), .sclk(sclk), .mosi(mosi), .done(sh_done), .rx(sh_rx)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= ST_IDLE;
      addr     <= '0;
      total    <= '0;
      idx      <= '0;
      busy     <= 1'b0;
      rd_valid <= 1'b0;
      rd_data  <= '0;
      done     <= 1'b0;
      error    <= 1'b0;
      link_en  <= 1'b0;
      cs_n     <= 1'b1;
    end else begin
      rd_valid <= 1'b0;
      done     <= 1'b0;
      error    <= 1'b0;
      case (st)
        ST_IDLE: begin
          if (reject_ev) error <= 1'b1;
          if (accept_ev) begin
            addr    <= eff_addr(req_offset, cfg_base);
            total   <= IDX_W'(req_count) + IDX_W'(HDR_BYTES);
            link_en <= 1'b1;
            busy    <= 1'b1;
            st      <= ST_ENA;
          end
        end
        ST_ENA: begin
          cs_n <= 1'b0;
          st   <= ST_SEL;
        end
        ST_SEL: begin
          idx <= '0;
          st  <= ST_XFER;
        end
        ST_XFER: begin
          if (sh_done) begin
            if (idx >= IDX_W'(HDR_BYTES)) begin
              rd_valid <= 1'b1;
              rd_data  <= sh_rx;
            end
            if (last_byte) begin
              cs_n <= 1'b1;
              st   <= ST_DESEL;
            end else begin
              idx <= idx + 1'b1;
            end
          end
        end
        ST_DESEL: begin
          link_en <= 1'b0;
          busy    <= 1'b0;
          done    <= 1'b1;
          st      <= ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  AST_CS_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_n |-> link_en) else $error("select without enable"); // R1
  AST_EN_BEFORE_CS: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cs_n) |-> $past(link_en)) else $error("select too early"); // R1
  AST_CS_BEFORE_DIS: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(link_en) |-> $past(cs_n)) else $error("enable dropped early"); // R1
  AST_REFUSE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    error |-> (!busy && !link_en && cs_n)) else $error("refused yet active"); // R6
  AST_BUSY_SPAN: assert property (@(posedge clk) disable iff (!rst_n)
    (link_en || !cs_n) |-> busy) else $error("busy gap"); // R8
  AST_DONE_WITH_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $fell(busy)) else $error("done misplaced"); // R8
  AST_IGNORE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done) |=> !error) else $error("request taken while busy"); // R9
  AST_NO_DATA_AFTER_CLOSE: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> !cs_n || $rose(cs_n)) else $error("data outside access"); // R4
endmodule

// File: tb/spi_rom_reader_test.sv
module spi_rom_reader_test;
  localparam int CNT_W = 8;
  localparam int HALF_W = 8;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              req_valid = 1'b0;
  logic [15:0]       req_offset = '0;
  logic [CNT_W-1:0]  req_count = '0;
  logic [31:0]       cfg_base = '0;
  logic              cfg_present = 1'b1;
  logic              cfg_absent = 1'b0;
  logic [HALF_W-1:0] cfg_half = 8'd2;
  logic busy, rd_valid, done, error, link_en, cs_n, sclk, mosi;
  logic [7:0] rd_data;
  logic miso = 1'b0;

  int total = 0;
  int bad = 0;
  int done_cnt = 0;
  logic [15:0] exp_addr;
  logic [7:0]  exp_q[$];

  always #5 clk = ~clk;

  spi_rom_reader #(.CNT_W(CNT_W), .HALF_W(HALF_W)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_offset(req_offset),
    .req_count(req_count), .cfg_base(cfg_base), .cfg_present(cfg_present),
    .cfg_absent(cfg_absent), .cfg_half(cfg_half), .busy(busy),
    .rd_valid(rd_valid), .rd_data(rd_data), .done(done), .error(error),
    .link_en(link_en), .cs_n(cs_n), .sclk(sclk), .mosi(mosi), .miso(miso)
  );

  function automatic logic [7:0] rom_byte(input logic [15:0] a);
    return a[7:0] * 8'd37 + a[15:8] + 8'h81;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // memory model: shift in on rising sclk, present next bit on falling sclk
  int          bitcnt;
  logic [23:0] rx24;
  always @(posedge sclk or posedge cs_n) begin
    if (cs_n) bitcnt <= 0;
    else begin
      if (bitcnt < 24) rx24 <= {rx24[22:0], mosi};
      bitcnt <= bitcnt + 1;
    end
  end
  always @(negedge sclk) begin
    if (!cs_n && bitcnt >= 24) begin
      automatic int k = bitcnt - 24;
      automatic logic [7:0] b = rom_byte(rx24[15:0] + 16'(k / 8));
      miso <= b[7 - (k % 8)];
    end
  end

  // high phase width measure
  int hcnt = 0, hmin = 1000, hmax = 0;
  always @(negedge clk) begin
    if (sclk) hcnt++;
    else if (hcnt != 0) begin
      if (hcnt < hmin) hmin = hcnt;
      if (hcnt > hmax) hmax = hcnt;
      hcnt = 0;
    end
  end

  // monitor: scoreboard and close ordering
  logic prev_cs = 1'b1, prev_en = 1'b0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (rd_valid) begin
        if (exp_q.size() == 0) check("R9 unexpected byte", {24'h0, rd_data}, 32'hFFFF);
        else check("R4 R2 R5 data byte", {24'h0, rd_data}, {24'h0, exp_q.pop_front()});
      end
      if (done) begin
        done_cnt++;
        check("R1 close order prev", {prev_cs, prev_en}, 2'b11);
        check("R8 close state", {cs_n, link_en, busy}, 3'b100);
        check("R4 R2 command and R5 address", rx24, {8'h03, exp_addr});
        check("R4 R10 queue drained", exp_q.size(), 0);
      end
      prev_cs = cs_n;
      prev_en = link_en;
    end
  end

  task automatic run_read(input logic [15:0] off, input int cnt, input logic [31:0] base,
                          input logic [7:0] half, input bit poke_busy);
    int base_done;
    cfg_base = base;
    cfg_half = half;
    exp_addr = off + base[15:0];
    for (int i = 0; i < cnt; i++) exp_q.push_back(rom_byte(exp_addr + 16'(i)));
    hmin = 1000; hmax = 0;
    base_done = done_cnt;
    @(negedge clk);
    req_offset = off; req_count = CNT_W'(cnt); req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    check("R1 enable first", {link_en, cs_n, busy}, 3'b111);
    @(negedge clk);
    check("R1 select second", {link_en, cs_n}, 2'b10);
    if (poke_busy) begin
      repeat (20) @(negedge clk);
      req_offset = 16'h1234; req_count = 8'd5; req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
    end
    while (done_cnt == base_done) @(negedge clk);
    if (cnt > 0 || half != 0) begin
      check("R7 high phase min", hmin, (half == 0) ? 1 : half);
      check("R7 high phase max", hmax, (half == 0) ? 1 : half);
    end
    repeat (30) @(negedge clk);
    check("R9 stays idle", {busy, link_en, cs_n}, 3'b001);
    check("R9 one done", done_cnt, base_done + 1);
  endtask

  task automatic run_refuse(input logic [31:0] base, input logic pres, input logic abs_f,
                            input string tag);
    cfg_base = base; cfg_present = pres; cfg_absent = abs_f;
    @(negedge clk);
    req_valid = 1'b1; req_count = 8'd2;
    @(negedge clk);
    req_valid = 1'b0;
    check(tag, {error, busy, link_en, cs_n}, 4'b1001);
    @(negedge clk);
    check(tag, {error, busy, link_en, cs_n}, 4'b0001);
    cfg_present = 1'b1; cfg_absent = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R11 reset state", {cs_n, link_en, sclk, mosi, busy, rd_valid, done, error}, 8'b1000_0000);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    run_read(16'h0010, 4, 32'h0000_0100, 8'd2, 1'b0);
    run_read(16'hFFF0, 3, 32'h0000_0020, 8'd0, 1'b0);   // R5 wrap
    run_read(16'h0040, 0, 32'h0000_0000, 8'd1, 1'b0);   // R10
    run_read(16'h0200, 6, 32'h0000_1000, 8'd3, 1'b1);   // R9 poke, R7 slow
    run_refuse(32'h0001_0000, 1'b1, 1'b0, "R6 base too large");
    run_refuse(32'h0000_0000, 1'b0, 1'b0, "R6 not present");
    run_refuse(32'h0000_0000, 1'b1, 1'b1, "R6 absent flag");
    run_read(16'h0007, 2, 32'h0000_FFFF, 8'd1, 1'b0);   // R5 max base
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #1500000;
    total++; bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule